// File: doc/BRIEF.md
# SDRAM initialization and refresh sequencer

This block owns the SDRAM command pins from reset until the memory is usable, and afterwards keeps the memory refreshed. Coming out of reset it closes every bank, performs one auto refresh, writes the mode register from a set of configuration inputs, performs a second auto refresh, and then raises a ready flag. Each command is separated from the next by the recovery time the previous command needs, counted in clocks.

Once ready, an interval timer raises a refresh request once per refresh slot. The slot length in clocks is the refresh period divided by the number of rows that must be refreshed, rounded down. A user-side memory controller sees the request, closes its open rows, and answers with a grant. The sequencer then issues the refresh. If a whole slot passes while a request is still waiting, the next grant is answered with two refreshes in a row instead of one. The request stays high until the last refresh has recovered, so the controller knows when it may drive the bus again.

Top module: `sdram_init_refresh`

## Requirements
- R1: While reset is asserted, all four command strobes are high (deselect), the address and bank outputs are zero, and ready, ref_req and cfg_err are low.
- R2: After reset is released, the commands issued before ready are, in order: precharge-all (strobes cs/ras/cas/we = 0,0,1,0 with address bit AP_BIT = 10 high and all other address bits zero), auto refresh (0,0,0,1, address zero), mode register write (0,0,0,0), auto refresh. The precharge-all appears in the first cycle after reset release, and the bank outputs are zero for every command.
- R3: The next command after a precharge-all comes T_RP clocks later. After an auto refresh it comes T_RFC clocks later. After a mode register write it comes T_MRD clocks later. The cycles in between carry a no-operation (0,1,1,1).
- R4: The mode word on the address bus has this layout: bits 2:0 are the burst length code (000=1, 001=2, 010=4, 011=8, 111=full page), bit 3 is the burst type (1 = interleaved), bits 6:4 are the CAS latency code (010=2, 011=3), bit 9 selects single-location writes, and bits 8:7 and 11:10 are zero.
- R5: A CAS latency code other than 010 or 011 is replaced by 011. A burst length code of 100, 101 or 110, or 111 with interleaved bursts, is replaced by 000. In either case cfg_err goes high together with the mode write and stays high until reset.
- R6: The configuration inputs are used only in the cycle the mode write is issued. Later changes produce no command and leave cfg_err unchanged.
- R7: ready rises T_RFC clocks after the second initialization refresh and stays high until reset.
- R8: ref_req rises REF_INTERVAL = CLK_KHZ*REF_MS/REF_ROWS clocks after ready rises, and a new slot begins every REF_INTERVAL clocks after that.
- R9: A refresh is issued in the cycle after ref_gnt is sampled high while ref_req is high. ref_req then falls T_RFC clocks after the last refresh of that service.
- R10: While ref_req is high and ref_gnt is low, no refresh is issued and ref_req stays high.
- R11: If a slot boundary passes while a request is still waiting, the next grant produces two refreshes T_RFC apart. After those two refreshes, the following service produces a single refresh again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst_len | input | 3 | Burst length code for the mode word |
| cfg_interleave | input | 1 | Burst type, 1 = interleaved |
| cfg_cas_lat | input | 3 | CAS latency code for the mode word |
| cfg_single_wr | input | 1 | Single-location write bursts |
| ref_gnt | input | 1 | Controller has closed its rows; refresh may go |
| sd_cs_n | output | 1 | Chip select strobe, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write strobe, active low |
| sd_addr | output | ADDR_W | Address bus, carries the mode word and the all-banks bit |
| sd_bank | output | BANK_W | Bank select, held zero |
| ref_req | output | 1 | Refresh wanted, held until service completes |
| ready | output | 1 | Initialization complete |
| cfg_err | output | 1 | Reserved configuration code was replaced |

## Verification
The initialization sequence is run under three configurations: one legal word with single-location writes, one with both a reserved CAS latency and full page combined with interleaving, and one legal full-page word. These separate a correct field layout from a wrong one, and show whether each substitution rule fires independently. The refresh side is tried with a grant delayed by two cycles, which exposes any refresh issued without permission. It is then tried with a grant withheld past a whole slot, which has to produce exactly two refreshes, followed by an immediate grant that has to produce exactly one. A final stretch changes the configuration inputs after ready to show that they are ignored.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

  localparam int MODE_W = 12;

  // strobe order: {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_DESEL = 4'b1111,
    CMD_NOP   = 4'b0111,
    CMD_PALL  = 4'b0010,
    CMD_AREF  = 4'b0001,
    CMD_MRS   = 4'b0000
  } sd_cmd_e;

  typedef enum logic [3:0] {
    ST_BOOT,
    ST_PALL,
    ST_W_RP,
    ST_IREF1,
    ST_W_RFC1,
    ST_MRS,
    ST_W_MRD,
    ST_IREF2,
    ST_W_RFC2,
    ST_RUN,
    ST_AREF,
    ST_W_ARFC
  } seq_state_e;

endpackage

// File: rtl/sdinit_modeword.sv
module sdinit_modeword
  import sdinit_pkg::*;
(
  input  logic [2:0]        burst_len,
  input  logic              interleave,
  input  logic [2:0]        cas_lat,
  input  logic              single_wr,
  output logic [MODE_W-1:0] word,
  output logic              bad
);

  logic       bl_ok;
  logic       cl_ok;
  logic [2:0] bl_use;
  logic [2:0] cl_use;

  always_comb begin
    bl_ok = (burst_len[2] == 1'b0) || ((burst_len == 3'b111) && !interleave);
    cl_ok = (cas_lat == 3'b010) || (cas_lat == 3'b011);
    bl_use = bl_ok ? burst_len : 3'b000;
    cl_use = cl_ok ? cas_lat : 3'b011;
    // {11:10 zero, 9 single write, 8:7 zero, 6:4 latency, 3 type, 2:0 length}
    word = {2'b00, single_wr, 2'b00, cl_use, interleave, bl_use};
    bad  = !(bl_ok && cl_ok);
  end

endmodule

// File: rtl/sdinit_ref_timer.sv
module sdinit_ref_timer #(
  parameter int INTERVAL = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic served,
  output logic pending,
  output logic overrun
);

  localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          miss_q, miss_d;
  logic          expire;

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (run_en) begin
      if (cnt_q == '0) begin
        cnt_d  = RELOAD;
        expire = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    pend_d = expire | (pend_q & ~served);
    if (expire) miss_d = pend_q & ~served;
    else        miss_d = miss_q & ~served;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= RELOAD;
      pend_q <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      miss_q <= miss_d;
    end
  end

  assign pending = pend_q;
  assign overrun = miss_q;

endmodule

// File: rtl/sdinit_seq.sv
module sdinit_seq
  import sdinit_pkg::*;
#(
  parameter int T_RP   = 2,
  parameter int T_RFC  = 7,
  parameter int T_MRD  = 2,
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              mode_bad,
  input  logic              ref_pend,
  input  logic              ref_miss,
  input  logic              ref_gnt,
  output logic [3:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic              ready,
  output logic              cfg_err,
  output logic              served
);

  localparam int T_MAX = (T_RFC > T_RP) ? ((T_RFC > T_MRD) ? T_RFC : T_MRD)
                                        : ((T_RP > T_MRD) ? T_RP : T_MRD);
  localparam int WCW = $clog2(T_MAX) + 1;
  localparam logic [WCW-1:0] GAP_RP  = WCW'(T_RP - 2);
  localparam logic [WCW-1:0] GAP_RFC = WCW'(T_RFC - 2);
  localparam logic [WCW-1:0] GAP_MRD = WCW'(T_MRD - 2);

  seq_state_e        state_q, state_d;
  logic [WCW-1:0]    wcnt_q, wcnt_d;
  logic              more_q, more_d;
  logic              wait_done;
  sd_cmd_e           cmd_d;
  logic [3:0]        cmd_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic              ready_d, ready_q;
  logic              err_d, err_q;

  assign wait_done = (wcnt_q == '0);

  // next state
  always_comb begin
    state_d = state_q;
    wcnt_d  = wcnt_q;
    more_d  = more_q;
    served  = 1'b0;
    case (state_q)
      ST_BOOT:  state_d = ST_PALL;
      ST_PALL: begin
        state_d = ST_W_RP;
        wcnt_d  = GAP_RP;
      end
      ST_W_RP: begin
        if (wait_done) state_d = ST_IREF1;
        else           wcnt_d  = wcnt_q - 1'b1;
      end
      ST_IREF1: begin
        state_d = ST_W_RFC1;
        wcnt_d  = GAP_RFC;
      end
      ST_W_RFC1: begin
        if (wait_done) state_d = ST_MRS;
        else           wcnt_d  = wcnt_q - 1'b1;
      end
      ST_MRS: begin
        state_d = ST_W_MRD;
        wcnt_d  = GAP_MRD;
      end
      ST_W_MRD: begin
        if (wait_done) state_d = ST_IREF2;
        else           wcnt_d  = wcnt_q - 1'b1;
      end
      ST_IREF2: begin
        state_d = ST_W_RFC2;
        wcnt_d  = GAP_RFC;
      end
      ST_W_RFC2: begin
        if (wait_done) state_d = ST_RUN;
        else           wcnt_d  = wcnt_q - 1'b1;
      end
      ST_RUN: begin
        if (ref_pend && ref_gnt) begin
          state_d = ST_AREF;
          more_d  = ref_miss;
        end
      end
      ST_AREF: begin
        state_d = ST_W_ARFC;
        wcnt_d  = GAP_RFC;
      end
      ST_W_ARFC: begin
        if (wait_done) begin
          if (more_q) begin
            state_d = ST_AREF;
            more_d  = 1'b0;
          end else begin
            state_d = ST_RUN;
            served  = 1'b1;
          end
        end else begin
          wcnt_d = wcnt_q - 1'b1;
        end
      end
      default: state_d = ST_BOOT;
    endcase
  end

  // pin image for the state being entered
  always_comb begin
    cmd_d  = CMD_NOP;
    addr_d = '0;
    case (state_d)
      ST_BOOT: cmd_d = CMD_DESEL;
      ST_PALL: begin
        cmd_d          = CMD_PALL;
        addr_d[AP_BIT] = 1'b1;
      end
      ST_IREF1, ST_IREF2, ST_AREF: cmd_d = CMD_AREF;
      ST_MRS: begin
        cmd_d  = CMD_MRS;
        addr_d = ADDR_W'(mode_word);
      end
      default: cmd_d = CMD_NOP;
    endcase
    ready_d = (state_d == ST_RUN) || (state_d == ST_AREF) || (state_d == ST_W_ARFC);
    err_d   = (state_d == ST_MRS) ? mode_bad : err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_BOOT;
      wcnt_q  <= '0;
      more_q  <= 1'b0;
      cmd_q   <= CMD_DESEL;
      addr_q  <= '0;
      ready_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
      more_q  <= more_d;
      cmd_q   <= cmd_d;
      addr_q  <= addr_d;
      ready_q <= ready_d;
      err_q   <= err_d;
    end
  end

  assign cmd     = cmd_q;
  assign addr    = addr_q;
  assign bank    = '0;
  assign ready   = ready_q;
  assign cfg_err = err_q;

endmodule

// File: rtl/sdram_init_refresh.sv
module sdram_init_refresh
  import sdinit_pkg::*;
#(
  parameter int CLK_KHZ  = 100000,
  parameter int REF_MS   = 64,
  parameter int REF_ROWS = 4096,
  parameter int T_RP     = 2,
  parameter int T_RFC    = 7,
  parameter int T_MRD    = 2,
  parameter int ADDR_W   = 12,
  parameter int BANK_W   = 2,
  parameter int AP_BIT   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_interleave,
  input  logic [2:0]        cfg_cas_lat,
  input  logic              cfg_single_wr,
  input  logic              ref_gnt,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BANK_W-1:0] sd_bank,
  output logic              ref_req,
  output logic              ready,
  output logic              cfg_err
);

  localparam int REF_INTERVAL = (CLK_KHZ * REF_MS) / REF_ROWS;

  logic [MODE_W-1:0] mode_word;
  logic              mode_bad;
  logic              pend;
  logic              miss;
  logic              served;
  logic [3:0]        cmd;

  sdinit_modeword u_mode (
    .burst_len  (cfg_burst_len),
    .interleave (cfg_interleave),
    .cas_lat    (cfg_cas_lat),
    .single_wr  (cfg_single_wr),
    .word       (mode_word),
    .bad        (mode_bad)
  );

  sdinit_ref_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (ready),
    .served  (served),
    .pending (pend),
    .overrun (miss)
  );

  sdinit_seq #(
    .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .AP_BIT(AP_BIT)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_word (mode_word),
    .mode_bad  (mode_bad),
    .ref_pend  (pend),
    .ref_miss  (miss),
    .ref_gnt   (ref_gnt),
    .cmd       (cmd),
    .addr      (sd_addr),
    .bank      (sd_bank),
    .ready     (ready),
    .cfg_err   (cfg_err),
    .served    (served)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign ref_req = pend;

endmodule

// File: rtl/sdinit_chk.sv
module sdinit_chk #(
  parameter int T_RP   = 2,
  parameter int T_RFC  = 7,
  parameter int T_MRD  = 2,
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2,
  parameter int AP_BIT = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [ADDR_W-1:0] sd_addr,
  input logic [BANK_W-1:0] sd_bank,
  input logic              ref_req,
  input logic              ref_gnt,
  input logic              ready
);

  localparam int SW = $clog2(T_RFC + T_RP + T_MRD) + 2;
  localparam logic [ADDR_W-1:0] AP_ONLY = ADDR_W'(1) << AP_BIT;

  logic [3:0]    cmd;
  logic          active;
  logic [SW-1:0] since_q;
  logic [SW-1:0] need_q;
  logic [2:0]    step_q;
  logic [3:0]    exp_init;

  assign cmd    = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign active = !sd_cs_n && !(sd_ras_n && sd_cas_n && sd_we_n);

  always_comb begin
    case (step_q)
      3'd0:    exp_init = 4'b0010;
      3'd1:    exp_init = 4'b0001;
      3'd2:    exp_init = 4'b0000;
      default: exp_init = 4'b0001;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '1;
      need_q  <= '0;
      step_q  <= '0;
    end else begin
      if (active) begin
        since_q <= SW'(1);
        if (cmd == 4'b0010)      need_q <= SW'(T_RP);
        else if (cmd == 4'b0001) need_q <= SW'(T_RFC);
        else                     need_q <= SW'(T_MRD);
        if (!ready && step_q != 3'd4) step_q <= step_q + 3'd1;
      end else if (since_q != '1) begin
        since_q <= since_q + 1'b1;
      end
    end
  end

  // R3
  gap_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> since_q >= need_q);

  // R2
  init_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !ready) |-> (cmd == exp_init && step_q != 3'd4 && sd_bank == '0 &&
      (cmd == 4'b0000 || sd_addr == ((cmd == 4'b0010) ? AP_ONLY : '0))));

  // R4
  mode_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cmd == 4'b0000) |->
      (sd_addr[11:10] == 2'b00 && sd_addr[8:7] == 2'b00 &&
       (sd_addr[6:4] == 3'b010 || sd_addr[6:4] == 3'b011)));

  // R7
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R10
  ref_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && active) |-> (cmd == 4'b0001 && ref_req && $past(ref_gnt)));

endmodule

bind sdram_init_refresh sdinit_chk #(
  .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .AP_BIT(AP_BIT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sd_cs_n  (sd_cs_n),
  .sd_ras_n (sd_ras_n),
  .sd_cas_n (sd_cas_n),
  .sd_we_n  (sd_we_n),
  .sd_addr  (sd_addr),
  .sd_bank  (sd_bank),
  .ref_req  (ref_req),
  .ref_gnt  (ref_gnt),
  .ready    (ready)
);

// File: tb/sim_sdram_init_refresh.sv
module sim_sdram_init_refresh;

  localparam int B_KHZ  = 1280;
  localparam int B_MS   = 64;
  localparam int B_ROWS = 4096;
  localparam int B_INT  = B_KHZ * B_MS / B_ROWS;
  localparam int B_RP   = 2;
  localparam int B_RFC  = 7;
  localparam int B_MRD  = 2;

  localparam int C_PALL = 1;
  localparam int C_REF1 = C_PALL + B_RP;
  localparam int C_MRS  = C_REF1 + B_RFC;
  localparam int C_REF2 = C_MRS + B_MRD;
  localparam int C_RDY  = C_REF2 + B_RFC;

  localparam logic [3:0] K_PALL = 4'b0010;
  localparam logic [3:0] K_REF  = 4'b0001;
  localparam logic [3:0] K_MRS  = 4'b0000;

  typedef struct {
    int         cyc;
    logic [3:0] cmd;
    logic [11:0] addr;
    string      tag;
  } exp_item_t;

  logic        clk;
  logic        rst_n;
  logic [2:0]  cfg_burst_len;
  logic        cfg_interleave;
  logic [2:0]  cfg_cas_lat;
  logic        cfg_single_wr;
  logic        ref_gnt;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [11:0] sd_addr;
  logic [1:0]  sd_bank;
  logic        ref_req;
  logic        ready;
  logic        cfg_err;

  int        total;
  int        bad;
  int        cyc;
  bit        finished;
  exp_item_t expq[$];

  sdram_init_refresh #(
    .CLK_KHZ(B_KHZ), .REF_MS(B_MS), .REF_ROWS(B_ROWS),
    .T_RP(B_RP), .T_RFC(B_RFC), .T_MRD(B_MRD)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_burst_len(cfg_burst_len), .cfg_interleave(cfg_interleave),
    .cfg_cas_lat(cfg_cas_lat), .cfg_single_wr(cfg_single_wr),
    .ref_gnt(ref_gnt),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .sd_bank(sd_bank),
    .ref_req(ref_req), .ready(ready), .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push(input int c, input logic [3:0] k, input logic [11:0] a, input string t);
    exp_item_t it;
    it.cyc = c; it.cmd = k; it.addr = a; it.tag = t;
    expq.push_back(it);
  endtask

  task automatic wait_cyc(input int n);
    while (cyc != n) @(negedge clk);
  endtask

  // monitor: every issued command is popped and compared
  always @(negedge clk) begin
    if (rst_n && !sd_cs_n && !(sd_ras_n && sd_cas_n && sd_we_n)) begin
      if (expq.size() == 0) begin
        check(1'b0, "R10 unexpected command", int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 15);
      end else begin
        exp_item_t it;
        it = expq.pop_front();
        check(cyc == it.cyc, {it.tag, " cycle"}, cyc, it.cyc);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == it.cmd, {it.tag, " strobes"},
              int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), int'(it.cmd));
        check(sd_addr == it.addr && sd_bank == 2'b00, {it.tag, " address"},
              int'({sd_bank, sd_addr}), int'(it.addr));
      end
    end
  end

  task automatic boot(input logic [2:0] bl, input logic il, input logic [2:0] cl,
                      input logic sw, input logic [11:0] word, input logic err);
    @(negedge clk);
    rst_n = 1'b0;
    ref_gnt = 1'b0;
    cfg_burst_len = bl; cfg_interleave = il; cfg_cas_lat = cl; cfg_single_wr = sw;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'hF, "R1 strobes", int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 15);
    check(sd_addr == 0 && sd_bank == 0, "R1 address", int'(sd_addr), 0);
    check(!ready && !ref_req && !cfg_err, "R1 flags", int'({ready, ref_req, cfg_err}), 0);
    expq.delete();
    // R2 order, R3 spacing, R4 layout, R5 substitution
    push(C_PALL, K_PALL, 12'h400, "R2 precharge-all");
    push(C_REF1, K_REF,  12'h000, "R3 first refresh");
    push(C_MRS,  K_MRS,  word,    "R4 R5 mode write");
    push(C_REF2, K_REF,  12'h000, "R3 second refresh");
    rst_n = 1'b1;
    wait_cyc(C_RDY - 1);
    check(ready == 1'b0, "R7 ready early", int'(ready), 0);
    wait_cyc(C_RDY);
    check(ready == 1'b1, "R7 ready rise", int'(ready), 1);
    check(cfg_err == err, "R5 cfg_err", int'(cfg_err), int'(err));
    check(expq.size() == 0, "R2 init commands", expq.size(), 0);
  endtask

  initial begin
    int q1, q2, q3, q4;
    total = 0; bad = 0; finished = 0;
    rst_n = 1'b0; ref_gnt = 1'b0;
    cfg_burst_len = 3'b000; cfg_interleave = 1'b0; cfg_cas_lat = 3'b010; cfg_single_wr = 1'b0;

    // legal word: length 4, sequential, latency 3, single writes -> 0x232
    boot(3'b010, 1'b0, 3'b011, 1'b1, 12'h232, 1'b0);

    q1 = C_RDY + B_INT;
    wait_cyc(q1 - 1);
    check(ref_req == 1'b0, "R8 request early", int'(ref_req), 0);
    wait_cyc(q1);
    check(ref_req == 1'b1, "R8 request rise", int'(ref_req), 1);
    wait_cyc(q1 + 2);
    check(ref_req == 1'b1, "R10 request held without grant", int'(ref_req), 1);
    ref_gnt = 1'b1;
    push(q1 + 3, K_REF, 12'h000, "R9 granted refresh");
    wait_cyc(q1 + 2 + B_RFC);
    check(ref_req == 1'b1, "R9 request during recovery", int'(ref_req), 1);
    wait_cyc(q1 + 3 + B_RFC);
    check(ref_req == 1'b0, "R9 request fall", int'(ref_req), 0);
    ref_gnt = 1'b0;

    // withhold the grant across a full slot -> two refreshes (R11)
    q2 = q1 + B_INT;
    q3 = q2 + B_INT;
    wait_cyc(q2);
    check(ref_req == 1'b1, "R8 second slot", int'(ref_req), 1);
    wait_cyc(q3 + 2);
    check(ref_req == 1'b1, "R10 request still waiting", int'(ref_req), 1);
    ref_gnt = 1'b1;
    push(q3 + 3,         K_REF, 12'h000, "R11 first of pair");
    push(q3 + 3 + B_RFC, K_REF, 12'h000, "R11 second of pair");
    wait_cyc(q3 + 2 + 2 * B_RFC);
    check(ref_req == 1'b1, "R11 request until pair done", int'(ref_req), 1);
    wait_cyc(q3 + 3 + 2 * B_RFC);
    check(ref_req == 1'b0, "R11 request fall after pair", int'(ref_req), 0);
    ref_gnt = 1'b0;

    // next slot served at once -> single refresh
    q4 = q3 + B_INT;
    wait_cyc(q4 - 1);
    check(ref_req == 1'b0, "R8 slot after pair early", int'(ref_req), 0);
    wait_cyc(q4);
    check(ref_req == 1'b1, "R8 slot after pair", int'(ref_req), 1);
    ref_gnt = 1'b1;
    push(q4 + 1, K_REF, 12'h000, "R11 single after pair");
    wait_cyc(q4 + 1 + B_RFC);
    check(ref_req == 1'b0, "R9 single service fall", int'(ref_req), 0);
    ref_gnt = 1'b0;

    // R6: configuration changes after ready are ignored
    cfg_cas_lat = 3'b111; cfg_burst_len = 3'b101;
    wait_cyc(q4 + B_INT - 1);
    check(cfg_err == 1'b0, "R6 cfg_err unchanged", int'(cfg_err), 0);
    check(ready == 1'b1, "R7 ready still high", int'(ready), 1);
    check(expq.size() == 0, "R6 no extra commands", expq.size(), 0);

    // reserved latency and full page with interleave -> 0x038, error (R5)
    boot(3'b111, 1'b1, 3'b101, 1'b0, 12'h038, 1'b1);
    // full page sequential, latency 2, single writes -> 0x227 (R4)
    boot(3'b111, 1'b0, 3'b010, 1'b1, 12'h227, 1'b0);
    wait_cyc(C_RDY + 3);
    check(cfg_err == 1'b0, "R5 error cleared by reset", int'(cfg_err), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule